// File: doc/BRIEF.md
# Width-Selectable Integer ALU with Condition Flags

This block is the integer execution stage of a 64-bit datapath. Each accepted operation works on one of four operand widths: 8, 16, 32 or 64 bits. Only the low bits of each operand that fall inside the selected width take part. The result is cut to that width, and the bits above it are returned as zero. Four condition flags come out with each operation: zero, carry, sign and overflow. Carry and overflow are taken at the most significant bit of the selected width.

The block accepts one operation per cycle on `in_valid`. One cycle later it presents the registered result, the flags and a write-back qualifier on `out_valid`. Compare and test produce flags and leave `out_write` low, so the caller does not write the result back. The flags live in a register inside the block. Increment and decrement, zero-count shifts and the reserved code preserve some or all of the previous flag values.

The two operands are `opnd_s` (source) and `opnd_d` (destination). Single-operand operations use `opnd_d` only.

Top module: `szalu_core`

## Requirements
- R1: `width` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Operand bits above the selected width are ignored, and `out_result` bits above it are always zero.
- R2: The arithmetic codes on `op` return their result modulo 2^n for the selected width n: 0 gives d+1, 1 gives d-1, 2 gives -d, 4 gives d+s and 5 gives d-s.
- R3: Every operation that updates flags sets ZF when the width-limited result is zero and sets SF to the result's top bit. For add (op 4), CF is the carry out of bit n-1 and OF is signed overflow.
- R4: For subtract (op 5), compare (op 13) and negate (op 2, computed as 0-d), CF is the borrow, meaning unsigned minuend < subtrahend. OF is signed overflow of the difference.
- R5: Increment (op 0) and decrement (op 1) keep the previous CF. They update ZF and SF, and set OF when the result crosses the signed limit.
- R6: Multiply (op 6) returns the low n bits of the signed product. CF and OF are both set when the full product does not equal the sign extension of those n bits.
- R7: Complement (op 3, ~d), and (op 7), or (op 8), xor (op 9) and test (op 14, s&d) clear CF and OF. Xor of equal operands yields zero with ZF set.
- R8: Shift left (op 10), arithmetic right (op 11) and logical right (op 12) shift `opnd_d` by `shamt` mod n. CF is the last bit shifted out. OF is CF xor the result sign for left shift, 0 for arithmetic right shift, and the original top bit for logical right shift.
- R9: A shift whose masked count is zero returns `opnd_d` cut to width and leaves all four flags unchanged.
- R10: Compare (op 13) and test (op 14) update the flags and present their value on `out_result` with `out_write` low. All other defined codes drive `out_write` high.
- R11: An operation accepted with `in_valid` appears on the outputs with `out_valid` high on the next cycle. A cycle without `in_valid` gives `out_valid` low on the next cycle and leaves the flags unchanged.
- R12: Code 15 is reserved. It returns a zero result with `out_write` low and leaves the flags unchanged.
- R13: While `rst_n` is low at a clock edge, `out_valid`, `out_write`, `out_result` and all flags become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| width | input | 2 | Operand width select |
| opnd_s | input | 64 | Source operand |
| opnd_d | input | 64 | Destination operand |
| shamt | input | 6 | Immediate shift count |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 64 | Registered result, zero above width |
| out_write | output | 1 | Result is to be written back |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry or borrow flag |
| out_sf | output | 1 | Sign flag |
| out_of | output | 1 | Signed overflow flag |

## Verification
The assertions require reset to be applied before the first `in_valid`. They also require `op`, `width`, the operands and `shamt` to be known values whenever `in_valid` is high. Their `$past` terms refer to the inputs of the cycle that was accepted, so those inputs must be stable across the clock edge. The stimulus drives every input on the falling edge and raises `in_valid` only after reset is released. It uses each defined operation code and the reserved code, all four widths, and shift counts that are zero, in range and larger than the width.

// File: rtl/szalu_pkg.sv
// Package szalu_pkg
// Shared widths, the operation code set, the flag record and the width helpers
// for the width-selectable ALU. Assumes a datapath width that is a multiple of
// 8 bits with four width classes of 8, 16, 32 and 64 bits.
package szalu_pkg;

    localparam int XLEN = 64;
    localparam int SHW  = $clog2(XLEN);
    localparam int OPW  = 4;
    localparam int WSW  = 2;

    typedef enum logic [OPW-1:0] {
        OP_INC  = 4'd0,
        OP_DEC  = 4'd1,
        OP_NEG  = 4'd2,
        OP_NOT  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_MUL  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SAR  = 4'd11,
        OP_SHR  = 4'd12,
        OP_CMP  = 4'd13,
        OP_TEST = 4'd14,
        OP_RSV  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic sf;
        logic of;
    } alu_flags_t;

    // Ones over the low bits that belong to the selected width.
    function automatic logic [XLEN-1:0] width_mask(input logic [WSW-1:0] w);
        return {XLEN{1'b1}} >> (XLEN - (8 << w));
    endfunction

    // A single one at the top bit of the selected width.
    function automatic logic [XLEN-1:0] msb_mask(input logic [WSW-1:0] w);
        return XLEN'(1) << ((8 << w) - 1);
    endfunction

    // Mask that reduces a shift count modulo the selected width.
    function automatic logic [SHW-1:0] cnt_mask(input logic [WSW-1:0] w);
        return SHW'((8 << w) - 1);
    endfunction

    // Sign-extend the selected width of v to the full datapath.
    function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] v,
                                             input logic [WSW-1:0] w);
        if ((v & msb_mask(w)) != '0)
            return v | ~width_mask(w);
        else
            return v & width_mask(w);
    endfunction

endpackage

// File: rtl/szalu_arith.sv
// Module szalu_arith
// Adder/subtractor that serves increment, decrement, negate, add, subtract
// and compare. It returns the width-limited result with carry/borrow and
// signed overflow taken at the selected width's top bit. Purely combinational.
// Assumes op is one of the arithmetic codes. Other codes yield an add of the
// masked operands, which the caller discards.
module szalu_arith
    import szalu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [WSW-1:0]   width,
    input  logic [XLEN-1:0]  s_in,
    input  logic [XLEN-1:0]  d_in,
    output logic [XLEN-1:0]  res,
    output logic             cf,
    output logic             of
);

    logic [XLEN-1:0] m;
    logic [XLEN-1:0] hb;
    logic [XLEN-1:0] x;
    logic [XLEN-1:0] y;
    logic            is_sub;
    logic [XLEN:0]   r65;
    logic            xs;
    logic            ys;
    logic            rs;

    // Choose the two adder inputs and the direction for each operation.
    always_comb begin
        m      = width_mask(width);
        hb     = msb_mask(width);
        x      = d_in & m;
        y      = s_in & m;
        is_sub = 1'b0;
        case (op)
            OP_INC: y = XLEN'(1);
            OP_DEC: begin
                y      = XLEN'(1);
                is_sub = 1'b1;
            end
            OP_NEG: begin
                x      = '0;
                y      = d_in & m;
                is_sub = 1'b1;
            end
            OP_SUB, OP_CMP: is_sub = 1'b1;
            default: ;
        endcase
    end

    // Form the sum or difference and derive carry and overflow at the width.
    always_comb begin
        r65 = is_sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
        res = r65[XLEN-1:0] & m;
        xs  = |(x & hb);
        ys  = |(y & hb);
        rs  = |(res & hb);
        if (is_sub) begin
            cf = (x < y);
            of = (xs != ys) && (rs != xs);
        end else begin
            cf = |(r65 & ({1'b0, hb} << 1));
            of = (xs == ys) && (rs != xs);
        end
    end

endmodule

// File: rtl/szalu_logic.sv
// Module szalu_logic
// Bitwise unit for complement, and, or, xor and test. The result is cut to
// the selected width. Purely combinational. Assumes op is a bitwise code.
// Other codes give zero.
module szalu_logic
    import szalu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [WSW-1:0]   width,
    input  logic [XLEN-1:0]  s_in,
    input  logic [XLEN-1:0]  d_in,
    output logic [XLEN-1:0]  res
);

    logic [XLEN-1:0] raw;

    // Apply the selected bitwise function, then cut to width.
    always_comb begin
        case (op)
            OP_NOT:          raw = ~d_in;
            OP_AND, OP_TEST: raw = s_in & d_in;
            OP_OR:           raw = s_in | d_in;
            OP_XOR:          raw = s_in ^ d_in;
            default:         raw = '0;
        endcase
        res = raw & width_mask(width);
    end

endmodule

// File: rtl/szalu_shift.sv
// Module szalu_shift
// Immediate shifter for left, arithmetic right and logical right shifts at
// the selected width. The count is reduced modulo the width. The unit reports
// the last bit shifted out, the overflow rule for each kind of shift, and
// whether the reduced count is zero. Purely combinational.
module szalu_shift
    import szalu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [WSW-1:0]   width,
    input  logic [XLEN-1:0]  d_in,
    input  logic [SHW-1:0]   shamt,
    output logic [XLEN-1:0]  res,
    output logic             cf,
    output logic             of,
    output logic             zero_cnt
);

    logic [SHW-1:0]    cnt;
    logic [XLEN-1:0]   m;
    logic [XLEN-1:0]   hb;
    logic [XLEN-1:0]   dm;
    logic [XLEN-1:0]   sx;
    logic [2*XLEN-1:0] wide;
    logic [XLEN-1:0]   pick;

    // Reduce the count and prepare the shifted views of the operand.
    always_comb begin
        cnt      = shamt & cnt_mask(width);
        m        = width_mask(width);
        hb       = msb_mask(width);
        dm       = d_in & m;
        sx       = sext(d_in, width);
        wide     = {{XLEN{1'b0}}, dm} << cnt;
        pick     = XLEN'(1) << (cnt - 1'b1);
        zero_cnt = (cnt == '0);
    end

    // Select the result, the last bit out and overflow for the shift kind.
    always_comb begin
        case (op)
            OP_SHL: begin
                res = wide[XLEN-1:0] & m;
                cf  = |(wide & ({{XLEN{1'b0}}, hb} << 1));
                of  = cf ^ (|(res & hb));
            end
            OP_SAR: begin
                res = XLEN'($signed(sx) >>> cnt) & m;
                cf  = |(sx & pick);
                of  = 1'b0;
            end
            OP_SHR: begin
                res = dm >> cnt;
                cf  = |(dm & pick);
                of  = |(dm & hb);
            end
            default: begin
                res = dm;
                cf  = 1'b0;
                of  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/szalu_mul.sv
// Module szalu_mul
// Signed multiplier that keeps the low n bits of the 2n-bit product for the
// selected width n. It flags overflow when the full product differs from
// the sign extension of the kept bits. Purely combinational. The full
// double-width product is formed in one step.
module szalu_mul
    import szalu_pkg::*;
(
    input  logic [WSW-1:0]   width,
    input  logic [XLEN-1:0]  s_in,
    input  logic [XLEN-1:0]  d_in,
    output logic [XLEN-1:0]  res,
    output logic             ovf
);

    logic [XLEN-1:0]   a;
    logic [XLEN-1:0]   b;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   lx;

    // Multiply the sign-extended operands and test the kept half for fit.
    always_comb begin
        a    = sext(s_in, width);
        b    = sext(d_in, width);
        prod = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{b[XLEN-1]}}, b};
        res  = prod[XLEN-1:0] & width_mask(width);
        lx   = sext(res, width);
        ovf  = (prod != {{XLEN{lx[XLEN-1]}}, lx});
    end

endmodule

// File: rtl/szalu_core.sv
// Module szalu_core
// Top of the width-selectable integer ALU. It routes each accepted operation
// to its unit, forms ZF and SF from the width-limited result and merges the
// flags that are preserved. The result, write qualifier and flags are
// registered with one cycle of latency. Assumes inputs are known when in_valid
// is high. Uses a synchronous active-low reset.
module szalu_core
    import szalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   op,
    input  logic [WSW-1:0]   width,
    input  logic [XLEN-1:0]  opnd_s,
    input  logic [XLEN-1:0]  opnd_d,
    input  logic [SHW-1:0]   shamt,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_write,
    output logic             out_zf,
    output logic             out_cf,
    output logic             out_sf,
    output logic             out_of
);

    alu_op_e         op_e;
    logic [XLEN-1:0] ar_res;
    logic            ar_cf;
    logic            ar_of;
    logic [XLEN-1:0] lg_res;
    logic [XLEN-1:0] sh_res;
    logic            sh_cf;
    logic            sh_of;
    logic            sh_zero;
    logic [XLEN-1:0] mu_res;
    logic            mu_ovf;

    logic [XLEN-1:0] nxt_res;
    logic            nxt_write;
    logic            u_cf;
    logic            u_of;
    logic            keep_cf;
    logic            hold_all;
    alu_flags_t      nxt_flags;
    alu_flags_t      flags_q;

    assign op_e = alu_op_e'(op);

    szalu_arith u_arith (
        .op    (op_e),
        .width (width),
        .s_in  (opnd_s),
        .d_in  (opnd_d),
        .res   (ar_res),
        .cf    (ar_cf),
        .of    (ar_of)
    );

    szalu_logic u_logic (
        .op    (op_e),
        .width (width),
        .s_in  (opnd_s),
        .d_in  (opnd_d),
        .res   (lg_res)
    );

    szalu_shift u_shift (
        .op       (op_e),
        .width    (width),
        .d_in     (opnd_d),
        .shamt    (shamt),
        .res      (sh_res),
        .cf       (sh_cf),
        .of       (sh_of),
        .zero_cnt (sh_zero)
    );

    szalu_mul u_mul (
        .width (width),
        .s_in  (opnd_s),
        .d_in  (opnd_d),
        .res   (mu_res),
        .ovf   (mu_ovf)
    );

    // Pick the unit result, write qualifier and flag-preservation controls.
    always_comb begin
        nxt_res   = '0;
        nxt_write = 1'b1;
        u_cf      = 1'b0;
        u_of      = 1'b0;
        keep_cf   = 1'b0;
        hold_all  = 1'b0;
        case (op_e)
            OP_INC, OP_DEC: begin
                nxt_res = ar_res;
                u_of    = ar_of;
                keep_cf = 1'b1;
            end
            OP_NEG, OP_ADD, OP_SUB: begin
                nxt_res = ar_res;
                u_cf    = ar_cf;
                u_of    = ar_of;
            end
            OP_CMP: begin
                nxt_res   = ar_res;
                u_cf      = ar_cf;
                u_of      = ar_of;
                nxt_write = 1'b0;
            end
            OP_MUL: begin
                nxt_res = mu_res;
                u_cf    = mu_ovf;
                u_of    = mu_ovf;
            end
            OP_NOT, OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_res;
            end
            OP_TEST: begin
                nxt_res   = lg_res;
                nxt_write = 1'b0;
            end
            OP_SHL, OP_SAR, OP_SHR: begin
                nxt_res  = sh_res;
                u_cf     = sh_cf;
                u_of     = sh_of;
                hold_all = sh_zero;
            end
            default: begin
                nxt_res   = '0;
                nxt_write = 1'b0;
                hold_all  = 1'b1;
            end
        endcase
    end

    // Build the next flag set, keeping stored flags where an operation must.
    always_comb begin
        if (hold_all) begin
            nxt_flags = flags_q;
        end else begin
            nxt_flags.zf = (nxt_res == '0);
            nxt_flags.sf = |(nxt_res & msb_mask(width));
            nxt_flags.cf = keep_cf ? flags_q.cf : u_cf;
            nxt_flags.of = u_of;
        end
    end

    // Register the outcome of each accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_write  <= 1'b0;
            flags_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_res;
                out_write  <= nxt_write;
                flags_q    <= nxt_flags;
            end
        end
    end

    assign out_zf = flags_q.zf;
    assign out_cf = flags_q.cf;
    assign out_sf = flags_q.sf;
    assign out_of = flags_q.of;

endmodule

// File: rtl/szalu_chk.sv
// Module szalu_chk
// Protocol and flag-rule checker for szalu_core, attached with bind. Its
// properties relate accepted inputs to the registered outputs one cycle
// later. Assumes reset is applied before the first in_valid.
module szalu_chk
    import szalu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OPW-1:0]   op,
    input logic [WSW-1:0]   width,
    input logic [XLEN-1:0]  opnd_s,
    input logic [XLEN-1:0]  opnd_d,
    input logic [SHW-1:0]   shamt,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_result,
    input logic             out_write,
    input logic             out_zf,
    input logic             out_cf,
    input logic             out_sf,
    input logic             out_of
);

    logic is_shift;
    logic is_logic;
    assign is_shift = (op == OP_SHL) || (op == OP_SAR) || (op == OP_SHR);
    assign is_logic = (op == OP_NOT) || (op == OP_AND) || (op == OP_OR)
                   || (op == OP_XOR) || (op == OP_TEST);

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_result & ~width_mask($past(width))) == '0));

    a_r5_incdec_keep_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_INC || op == OP_DEC)) |=> $stable(out_cf));

    a_r7_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_logic) |=> (!out_cf && !out_of));

    a_r7_xor_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_XOR && opnd_s == opnd_d) |=> (out_result == '0 && out_zf));

    a_r9_shift_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift && ((shamt & cnt_mask(width)) == '0))
        |=> ($stable(out_zf) && $stable(out_cf) && $stable(out_sf) && $stable(out_of)
             && out_result == ($past(opnd_d) & width_mask($past(width)))));

    a_r10_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CMP || op == OP_TEST)) |=> (out_valid && !out_write));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_zf) && $stable(out_cf)
                       && $stable(out_sf) && $stable(out_of)));

    a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_RSV) |=> (!out_write && out_result == '0
                                        && $stable(out_zf) && $stable(out_cf)
                                        && $stable(out_sf) && $stable(out_of)));

endmodule

bind szalu_core szalu_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .width      (width),
    .opnd_s     (opnd_s),
    .opnd_d     (opnd_d),
    .shamt      (shamt),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_write  (out_write),
    .out_zf     (out_zf),
    .out_cf     (out_cf),
    .out_sf     (out_sf),
    .out_of     (out_of)
);

// File: tb/szalu_core_tb_top.sv
`timescale 1ns/1ps
// Bench for szalu_core: a vector table driven back to back, then directed
// sequences for flag preservation, idle cycles, the reserved code and reset.
module szalu_core_tb_top;

    localparam logic [3:0] C_INC = 4'd0,  C_DEC = 4'd1,  C_NEG = 4'd2,  C_NOT = 4'd3;
    localparam logic [3:0] C_ADD = 4'd4,  C_SUB = 4'd5,  C_MUL = 4'd6,  C_AND = 4'd7;
    localparam logic [3:0] C_OR  = 4'd8,  C_XOR = 4'd9,  C_SHL = 4'd10, C_SAR = 4'd11;
    localparam logic [3:0] C_SHR = 4'd12, C_CMP = 4'd13, C_TST = 4'd14, C_RSV = 4'd15;

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic [1:0]  w;
        logic [63:0] s;
        logic [63:0] d;
        logic [5:0]  sh;
        logic [63:0] res;
        logic        wr;
        logic [3:0]  fl;   // {ZF, CF, SF, OF}
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'd2, C_ADD, 2'd0, 64'h01, 64'h7F, 6'd0, 64'h80, 1'b1, 4'b0011},           // R2 0x7F+1
        '{8'd1, C_ADD, 2'd0, 64'h1234_5678_9ABC_DEFF, 64'hFFFF_FFFF_FFFF_FF01,
                6'd0, 64'h0, 1'b1, 4'b1100},                                         // R1 upper bits ignored
        '{8'd3, C_ADD, 2'd3, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 64'h0, 1'b1, 4'b1100}, // R3 quad carry
        '{8'd3, C_ADD, 2'd1, 64'h8000, 64'h8000, 6'd0, 64'h0, 1'b1, 4'b1101},        // R3 carry+overflow
        '{8'd4, C_SUB, 2'd2, 64'h1, 64'h0, 6'd0, 64'hFFFF_FFFF, 1'b1, 4'b0110},      // R4 borrow
        '{8'd4, C_SUB, 2'd0, 64'h01, 64'h80, 6'd0, 64'h7F, 1'b1, 4'b0001},           // R4 signed overflow
        '{8'd10, C_CMP, 2'd3, 64'h5, 64'h5, 6'd0, 64'h0, 1'b0, 4'b1000},             // R10 compare equal
        '{8'd4, C_NEG, 2'd1, 64'h0, 64'h8000, 6'd0, 64'h8000, 1'b1, 4'b0111},        // R4 negate minimum
        '{8'd4, C_NEG, 2'd0, 64'h0, 64'h0, 6'd0, 64'h0, 1'b1, 4'b1000},              // R4 negate zero
        '{8'd6, C_MUL, 2'd1, 64'h0100, 64'h0100, 6'd0, 64'h0, 1'b1, 4'b1101},        // R6 truncation
        '{8'd6, C_MUL, 2'd2, 64'hFFFF_FFFF, 64'h3, 6'd0, 64'hFFFF_FFFD, 1'b1, 4'b0010}, // R6 -1*3
        '{8'd6, C_MUL, 2'd3, 64'h1_0000_0000, 64'h1_0000_0000, 6'd0, 64'h0, 1'b1, 4'b1101}, // R6 quad
        '{8'd7, C_AND, 2'd2, 64'hF0F0_F0F0, 64'h0F0F_0F0F, 6'd0, 64'h0, 1'b1, 4'b1000}, // R7 and
        '{8'd7, C_OR,  2'd0, 64'h80, 64'h01, 6'd0, 64'h81, 1'b1, 4'b0010},           // R7 or
        '{8'd7, C_XOR, 2'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D,
                6'd0, 64'h0, 1'b1, 4'b1000},                                         // R7 xor self
        '{8'd7, C_NOT, 2'd1, 64'h0, 64'h00FF, 6'd0, 64'hFF00, 1'b1, 4'b0010},        // R7 complement
        '{8'd10, C_TST, 2'd0, 64'h80, 64'hFF, 6'd0, 64'h80, 1'b0, 4'b0010},          // R10 test
        '{8'd8, C_SHL, 2'd0, 64'h0, 64'h81, 6'd1, 64'h02, 1'b1, 4'b0101},            // R8 left
        '{8'd8, C_SHR, 2'd1, 64'h0, 64'h8001, 6'd1, 64'h4000, 1'b1, 4'b0101},        // R8 logical right
        '{8'd8, C_SAR, 2'd2, 64'h0, 64'h8000_0000, 6'd4, 64'hF800_0000, 1'b1, 4'b0010}, // R8 arithmetic right
        '{8'd8, C_SHL, 2'd3, 64'h0, 64'h1, 6'd63, 64'h8000_0000_0000_0000, 1'b1, 4'b0011}, // R8 max count
        '{8'd8, C_SHR, 2'd0, 64'h0, 64'h03, 6'd9, 64'h01, 1'b1, 4'b0100}             // R8 count mod 8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  width = '0;
    logic [63:0] opnd_s = '0;
    logic [63:0] opnd_d = '0;
    logic [5:0]  shamt = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_write;
    logic        out_zf, out_cf, out_sf, out_of;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    szalu_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .width(width),
        .opnd_s(opnd_s), .opnd_d(opnd_d), .shamt(shamt),
        .out_valid(out_valid), .out_result(out_result), .out_write(out_write),
        .out_zf(out_zf), .out_cf(out_cf), .out_sf(out_sf), .out_of(out_of)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [63:0] res,
                             input logic wr, input logic [3:0] fl);
        check(req, "valid",  {63'b0, out_valid}, 64'h1);
        check(req, "result", out_result, res);
        check(req, "write",  {63'b0, out_write}, {63'b0, wr});
        check(req, "flags",  {60'b0, out_zf, out_cf, out_sf, out_of}, {60'b0, fl});
    endtask

    task automatic drive(input logic [3:0] o, input logic [1:0] w,
                         input logic [63:0] s, input logic [63:0] d, input logic [5:0] sh);
        in_valid = 1'b1; op = o; width = w; opnd_s = s; opnd_d = d; shamt = sh;
    endtask

    // One operation followed by a check one cycle later.
    task automatic run_op(input string req, input logic [3:0] o, input logic [1:0] w,
                          input logic [63:0] s, input logic [63:0] d, input logic [5:0] sh,
                          input logic [63:0] res, input logic wr, input logic [3:0] fl);
        @(negedge clk);
        drive(o, w, s, d, sh);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(req, res, wr, fl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13", "valid",  {63'b0, out_valid}, 64'h0);
        check("R13", "result", out_result, 64'h0);
        check("R13", "flags",  {60'b0, out_zf, out_cf, out_sf, out_of}, 64'h0);
        rst_n = 1'b1;

        // R11: table driven back to back, one result per cycle
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0)
                check_out($sformatf("R%0d", VECS[i-1].req), VECS[i-1].res,
                          VECS[i-1].wr, VECS[i-1].fl);
            if (i < NV)
                drive(VECS[i].op, VECS[i].w, VECS[i].s, VECS[i].d, VECS[i].sh);
            else
                in_valid = 1'b0;
        end

        // R11: idle cycle drops valid and keeps flags (last vector left 0100)
        @(negedge clk);
        check("R11", "idle valid", {63'b0, out_valid}, 64'h0);
        check("R11", "idle flags", {60'b0, out_zf, out_cf, out_sf, out_of}, 64'h4);

        // R5: increment and decrement keep CF=1 from before
        run_op("R5", C_INC, 2'd0, 64'h0, 64'h7F, 6'd0, 64'h80, 1'b1, 4'b0111);
        run_op("R5", C_DEC, 2'd0, 64'h0, 64'h80, 6'd0, 64'h7F, 1'b1, 4'b0101);
        run_op("R5", C_DEC, 2'd1, 64'h0, 64'h0, 6'd0, 64'hFFFF, 1'b1, 4'b0110);
        // R9: count 16 at 16 bits masks to zero, flags held
        run_op("R9", C_SHL, 2'd1, 64'h0, 64'hAB_1234, 6'd16, 64'h1234, 1'b1, 4'b0110);
        run_op("R9", C_SAR, 2'd0, 64'h0, 64'h85, 6'd8, 64'h85, 1'b1, 4'b0110);
        // R12: reserved code
        run_op("R12", C_RSV, 2'd3, 64'h5, 64'h7, 6'd3, 64'h0, 1'b0, 4'b0110);
        // R10: compare overflow without write-back
        run_op("R10", C_CMP, 2'd0, 64'h01, 64'h80, 6'd0, 64'h7F, 1'b0, 4'b0001);

        // R13: reset during activity
        @(negedge clk);
        drive(C_ADD, 2'd0, 64'hFF, 64'hFF, 6'd0);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R13", "valid",  {63'b0, out_valid}, 64'h0);
        check("R13", "write",  {63'b0, out_write}, 64'h0);
        check("R13", "result", out_result, 64'h0);
        check("R13", "flags",  {60'b0, out_zf, out_cf, out_sf, out_of}, 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R11 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule